// File: doc/BRIEF.md
# Sleep and Wake Clock Controller

This controller owns the system clock enable of a small microcontroller across a low-power sleep state. In run mode it holds a clock source (fast internal oscillator or low-speed crystal) and a power-of-two division ratio, and it produces a one-cycle clock enable from them. Changing the source waits for the new oscillator to report ready, and the clock keeps running on the old source while the change is pending.

A sleep request counts only when the deep-sleep qualifier is set. After a short entry phase the system clock enable stops and the fast oscillator is switched off. A separate control decides whether the crystal stops during sleep, and with it the real-time clock enable. A wake interrupt restarts the clock. It comes back either on the pre-sleep source and divider or on a separately programmed wake source and divider, which then become the run settings. The clock enable stays low until the chosen oscillator is stable. A wake interrupt that arrives during the entry phase cancels the sleep.

Oscillators are modelled as an enable output and a ready input. All logic runs on one free-running reference clock, and the system clock is expressed as an enable on that clock.

Top module: `sleep_clk_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, the clock enable is low, the reported source and divider are 0, and busy and sleeping are low. The clock enable first pulses only after the fast oscillator reports ready.
- R2: Bit 0 of a 2-bit source code selects the oscillator: 0 selects the fast internal oscillator and 1 selects the crystal. Codes 2 and 3 alias 0 and 1.
- R3: A divider code d (0..3) gives exactly one clock-enable pulse every 2^d reference cycles while running.
- R4: A run-mode configuration write raises busy. Busy stays high and the reported source stays unchanged until the target oscillator is ready, and the clock enable keeps pulsing on the old source meanwhile.
- R5: A sleep request with the deep qualifier at 0 is ignored. With the qualifier at 1, the block enters sleep after ENTRY_CYC cycles. In sleep the clock enable is low and the sleeping flag is high.
- R6: In sleep with the crystal-stop control at 1, the crystal enable and the real-time clock enable are low. With the control at 0, the real-time clock enable stays high through sleep.
- R7: On wake with the wake-mode bit at 0, the source and divider are the ones used before sleep.
- R8: On wake with the wake-mode bit at 1, the source and divider take the wake fields. They remain the run settings after a later sleep and wake in which the wake-mode bit is 0.
- R9: After a wake interrupt, the clock enable stays low until the selected oscillator reports ready.
- R10: A wake interrupt during the entry phase cancels the sleep. The sleeping flag never rises and the clock enable keeps pulsing.
- R11: The clock enable is never high while the oscillator of the reported source is not ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Run-mode configuration write strobe |
| cfg_src_i | input | 2 | Run-mode source code |
| cfg_div_i | input | 2 | Run-mode divider code |
| wake_mode_i | input | 1 | Use the wake fields on wake-up |
| wake_src_i | input | 2 | Wake-up source code |
| wake_div_i | input | 2 | Wake-up divider code |
| xtal_stop_i | input | 1 | Stop the crystal during sleep |
| sleep_req_i | input | 1 | Wait-for-interrupt/event request |
| deep_i | input | 1 | Deep-sleep qualifier |
| wake_irq_i | input | 1 | Wake-up interrupt |
| fast_rdy_i | input | 1 | Fast oscillator stable |
| xtal_rdy_i | input | 1 | Crystal oscillator stable |
| fast_en_o | output | 1 | Fast oscillator enable |
| xtal_en_o | output | 1 | Crystal oscillator enable |
| sys_clk_en_o | output | 1 | System clock enable pulse |
| rtc_clk_en_o | output | 1 | Real-time clock enable |
| cur_src_o | output | 2 | Active run source code |
| cur_div_o | output | 2 | Active run divider code |
| switch_busy_o | output | 1 | Source change in progress |
| sleeping_o | output | 1 | Sleep state |

## Verification
The divider is tried with each of the four codes, and pulses are counted over a window that every ratio divides. A wrong mask or a wrong counter width shows up as a wrong count. Sleep is tried three ways: with the deep qualifier cleared, with a wake interrupt one cycle into entry, and with full entry. These separate the qualifier gate, the abort path and the timed entry. Wakes are run with wake mode off and on, and with the crystal both stopped and kept. This distinguishes restoring the old settings from adopting the wake fields and keeping them, and a release held for oscillator stabilisation from one that is not.

// File: rtl/sleep_clk_pkg.sv
package sleep_clk_pkg;
  typedef enum logic [2:0] {
    ST_RUN    = 3'd0,
    ST_SWITCH = 3'd1,
    ST_ENTER  = 3'd2,
    ST_SLEEP  = 3'd3,
    ST_WAKE   = 3'd4
  } ctl_state_e;

  localparam int unsigned NUM_OSC  = 2;
  localparam int unsigned OSC_FAST = 0;
  localparam int unsigned OSC_XTAL = 1;

  // oscillator index from a source code: bit 0 decides
  function automatic logic src_to_osc(input logic [1:0] src);
    return src[0];
  endfunction
endpackage

// File: rtl/clk_div_en.sv
module clk_div_en #(
  parameter int unsigned DIV_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             en_o
);
  localparam int unsigned CNT_W = (1 << DIV_W) - 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] mask;
  logic [CNT_W-1:0] one;

  assign one  = CNT_W'(1);
  // top code wraps to zero, minus one gives all ones
  assign mask = (one << div_i) - one;
  assign en_o = run_i && ((cnt_q & mask) == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (run_i) cnt_q <= cnt_q + one;
    else            cnt_q <= '0;
  end
endmodule

// File: rtl/osc_req.sv
module osc_req
  import sleep_clk_pkg::*;
#(
  parameter int unsigned N_OSC = NUM_OSC
) (
  input  ctl_state_e       state_i,
  input  logic             act_idx_i,
  input  logic             tgt_idx_i,
  input  logic             xtal_stop_i,
  output logic [N_OSC-1:0] en_o
);
  logic run_ph, sleep_ph, waking, switching;

  assign run_ph    = (state_i == ST_RUN) || (state_i == ST_SWITCH) || (state_i == ST_ENTER);
  assign sleep_ph  = (state_i == ST_SLEEP) || (state_i == ST_WAKE);
  assign waking    = (state_i == ST_WAKE);
  assign switching = (state_i == ST_SWITCH);

  for (genvar k = 0; k < N_OSC; k++) begin : g_osc
    if (k == OSC_XTAL) begin : g_xtal
      // crystal runs outside sleep; in sleep only if kept or needed for wake
      assign en_o[k] = !sleep_ph || !xtal_stop_i || (waking && tgt_idx_i == 1'(k));
    end else begin : g_fast
      assign en_o[k] = (run_ph && (act_idx_i == 1'(k) || (switching && tgt_idx_i == 1'(k))))
                     || (waking && tgt_idx_i == 1'(k));
    end
  end
endmodule

// File: rtl/sleep_fsm.sv
module sleep_fsm
  import sleep_clk_pkg::*;
#(
  parameter int unsigned SRC_W     = 2,
  parameter int unsigned DIV_W     = 2,
  parameter int unsigned ENTRY_CYC = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cfg_we_i,
  input  logic [SRC_W-1:0]   cfg_src_i,
  input  logic [DIV_W-1:0]   cfg_div_i,
  input  logic               sleep_req_i,
  input  logic               deep_i,
  input  logic               wake_irq_i,
  input  logic               wake_mode_i,
  input  logic [SRC_W-1:0]   wake_src_i,
  input  logic [DIV_W-1:0]   wake_div_i,
  input  logic [NUM_OSC-1:0] osc_rdy_i,
  output ctl_state_e         state_o,
  output logic [SRC_W-1:0]   cur_src_o,
  output logic [DIV_W-1:0]   cur_div_o,
  output logic               act_idx_o,
  output logic               tgt_idx_o
);
  localparam int unsigned ENT_W = (ENTRY_CYC > 1) ? $clog2(ENTRY_CYC) : 1;

  ctl_state_e       state_q, state_d;
  logic [SRC_W-1:0] cur_src_q, cur_src_d, pend_src_q, pend_src_d;
  logic [DIV_W-1:0] cur_div_q, cur_div_d, pend_div_q, pend_div_d;
  logic [ENT_W-1:0] ent_q, ent_d;
  logic             tgt_rdy;

  assign act_idx_o = src_to_osc(cur_src_q);
  assign tgt_idx_o = (state_q == ST_SWITCH) ? src_to_osc(pend_src_q) : src_to_osc(cur_src_q);
  assign tgt_rdy   = osc_rdy_i[tgt_idx_o];

  always_comb begin
    state_d    = state_q;
    cur_src_d  = cur_src_q;
    cur_div_d  = cur_div_q;
    pend_src_d = pend_src_q;
    pend_div_d = pend_div_q;
    ent_d      = ent_q;
    unique case (state_q)
      ST_RUN: begin
        if (cfg_we_i) begin
          pend_src_d = cfg_src_i;
          pend_div_d = cfg_div_i;
          state_d    = ST_SWITCH;
        end else if (sleep_req_i && deep_i) begin
          ent_d   = '0;
          state_d = ST_ENTER;
        end
      end
      ST_SWITCH: begin
        if (tgt_rdy) begin
          cur_src_d = pend_src_q;
          cur_div_d = pend_div_q;
          state_d   = ST_RUN;
        end
      end
      ST_ENTER: begin
        if (wake_irq_i)                            state_d = ST_RUN;
        else if (ent_q == ENT_W'(ENTRY_CYC - 1))   state_d = ST_SLEEP;
        else                                       ent_d   = ent_q + ENT_W'(1);
      end
      ST_SLEEP: begin
        if (wake_irq_i) begin
          if (wake_mode_i) begin
            cur_src_d = wake_src_i;
            cur_div_d = wake_div_i;
          end
          state_d = ST_WAKE;
        end
      end
      ST_WAKE: begin
        if (tgt_rdy) state_d = ST_RUN;
      end
      default: state_d = ST_WAKE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_WAKE;   // cold start waits for the fast oscillator
      cur_src_q  <= '0;
      cur_div_q  <= '0;
      pend_src_q <= '0;
      pend_div_q <= '0;
      ent_q      <= '0;
    end else begin
      state_q    <= state_d;
      cur_src_q  <= cur_src_d;
      cur_div_q  <= cur_div_d;
      pend_src_q <= pend_src_d;
      pend_div_q <= pend_div_d;
      ent_q      <= ent_d;
    end
  end

  assign state_o   = state_q;
  assign cur_src_o = cur_src_q;
  assign cur_div_o = cur_div_q;
endmodule

// File: rtl/sleep_clk_ctrl.sv
module sleep_clk_ctrl
  import sleep_clk_pkg::*;
#(
  parameter int unsigned SRC_W     = 2,
  parameter int unsigned DIV_W     = 2,
  parameter int unsigned ENTRY_CYC = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [SRC_W-1:0] cfg_src_i,
  input  logic [DIV_W-1:0] cfg_div_i,
  input  logic             wake_mode_i,
  input  logic [SRC_W-1:0] wake_src_i,
  input  logic [DIV_W-1:0] wake_div_i,
  input  logic             xtal_stop_i,
  input  logic             sleep_req_i,
  input  logic             deep_i,
  input  logic             wake_irq_i,
  input  logic             fast_rdy_i,
  input  logic             xtal_rdy_i,
  output logic             fast_en_o,
  output logic             xtal_en_o,
  output logic             sys_clk_en_o,
  output logic             rtc_clk_en_o,
  output logic [SRC_W-1:0] cur_src_o,
  output logic [DIV_W-1:0] cur_div_o,
  output logic             switch_busy_o,
  output logic             sleeping_o
);
  ctl_state_e         state;
  logic [NUM_OSC-1:0] osc_rdy, osc_en;
  logic               act_idx, tgt_idx, clk_run;

  assign osc_rdy[OSC_FAST] = fast_rdy_i;
  assign osc_rdy[OSC_XTAL] = xtal_rdy_i;

  sleep_fsm #(
    .SRC_W(SRC_W), .DIV_W(DIV_W), .ENTRY_CYC(ENTRY_CYC)
  ) u_fsm (
    .clk_i, .rst_ni, .cfg_we_i, .cfg_src_i, .cfg_div_i,
    .sleep_req_i, .deep_i, .wake_irq_i, .wake_mode_i, .wake_src_i, .wake_div_i,
    .osc_rdy_i (osc_rdy),
    .state_o   (state),
    .cur_src_o,
    .cur_div_o,
    .act_idx_o (act_idx),
    .tgt_idx_o (tgt_idx)
  );

  osc_req #(.N_OSC(NUM_OSC)) u_osc (
    .state_i     (state),
    .act_idx_i   (act_idx),
    .tgt_idx_i   (tgt_idx),
    .xtal_stop_i,
    .en_o        (osc_en)
  );

  assign clk_run = (state == ST_RUN) || (state == ST_SWITCH) || (state == ST_ENTER);

  clk_div_en #(.DIV_W(DIV_W)) u_div (
    .clk_i, .rst_ni,
    .run_i (clk_run),
    .div_i (cur_div_o),
    .en_o  (sys_clk_en_o)
  );

  assign fast_en_o     = osc_en[OSC_FAST];
  assign xtal_en_o     = osc_en[OSC_XTAL];
  assign rtc_clk_en_o  = osc_en[OSC_XTAL] && xtal_rdy_i;
  assign switch_busy_o = (state == ST_SWITCH);
  assign sleeping_o    = (state == ST_SLEEP);
endmodule

// File: rtl/sleep_clk_checker.sv
module sleep_clk_checker #(
  parameter int unsigned SRC_W = 2,
  parameter int unsigned DIV_W = 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wake_mode_i,
  input logic [SRC_W-1:0] wake_src_i,
  input logic [DIV_W-1:0] wake_div_i,
  input logic             xtal_stop_i,
  input logic             fast_rdy_i,
  input logic             xtal_rdy_i,
  input logic             sys_clk_en_o,
  input logic             rtc_clk_en_o,
  input logic [SRC_W-1:0] cur_src_o,
  input logic [DIV_W-1:0] cur_div_o,
  input logic             switch_busy_o,
  input logic             sleeping_o
);
  logic sel_rdy;
  assign sel_rdy = cur_src_o[0] ? xtal_rdy_i : fast_rdy_i;

  assert_sleep_no_clk_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleeping_o |-> !sys_clk_en_o);

  assert_rtc_stopped_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sleeping_o && xtal_stop_i) |-> !rtc_clk_en_o);

  assert_wake_restore_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(sleeping_o) && !$past(wake_mode_i)) |-> ($stable(cur_src_o) && $stable(cur_div_o)));

  assert_wake_fields_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(sleeping_o) && $past(wake_mode_i))
      |-> (cur_src_o == $past(wake_src_i) && cur_div_o == $past(wake_div_i)));

  assert_switch_done_rdy_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(switch_busy_o) |-> sel_rdy);

  assert_clk_needs_rdy_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_clk_en_o |-> sel_rdy);
endmodule

bind sleep_clk_ctrl sleep_clk_checker #(.SRC_W(SRC_W), .DIV_W(DIV_W)) u_chk (.*);

// File: tb/sim_sleep_clk_ctrl.sv
module sim_sleep_clk_ctrl;
  localparam int ENTRY     = 4;
  localparam int FAST_STAB = 6;
  localparam int XTAL_STAB = 20;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic cfg_we_i = 0, wake_mode_i = 0, xtal_stop_i = 0;
  logic sleep_req_i = 0, deep_i = 0, wake_irq_i = 0;
  logic [1:0] cfg_src_i = 0, cfg_div_i = 0, wake_src_i = 0, wake_div_i = 0;
  logic fast_rdy_i, xtal_rdy_i, fast_en_o, xtal_en_o;
  logic sys_clk_en_o, rtc_clk_en_o, switch_busy_o, sleeping_o;
  logic [1:0] cur_src_o, cur_div_o;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2 clk_i = ~clk_i;

  sleep_clk_ctrl #(.ENTRY_CYC(ENTRY)) u0 (.*);

  // oscillator models: ready after a fixed count of enabled cycles
  int fc, xc;
  always @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) fc <= 0;
    else if (!fast_en_o) fc <= 0;
    else if (fc < FAST_STAB) fc <= fc + 1;
  always @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) xc <= 0;
    else if (!xtal_en_o) xc <= 0;
    else if (xc < XTAL_STAB) xc <= xc + 1;
  assign fast_rdy_i = (fc == FAST_STAB);
  assign xtal_rdy_i = (xc == XTAL_STAB);

  task automatic tick();
    @(posedge clk_i); #1;
  endtask

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic count_pulses(input int win, output int n);
    n = 0;
    for (int i = 0; i < win; i++) begin
      tick();
      if (sys_clk_en_o) n++;
    end
  endtask

  task automatic wait_run();
    for (int i = 0; i < 200; i++) begin
      if (sys_clk_en_o && !switch_busy_o) break;
      tick();
    end
  endtask

  task automatic write_cfg(input logic [1:0] s, input logic [1:0] d);
    cfg_src_i = s; cfg_div_i = d; cfg_we_i = 1;
    tick();
    cfg_we_i = 0;
  endtask

  task automatic go_sleep();
    sleep_req_i = 1; deep_i = 1;
    tick();
    sleep_req_i = 0; deep_i = 0;
    repeat (ENTRY + 2) tick();
  endtask

  task automatic pulse_wake();
    wake_irq_i = 1;
    tick();
    wake_irq_i = 0;
  endtask

  task automatic t_reset();
    rst_ni = 0;
    repeat (3) tick();
    check(!sys_clk_en_o && cur_src_o == 0 && cur_div_o == 0 && !switch_busy_o && !sleeping_o,
          "R1 reset state", {cur_src_o, cur_div_o, sys_clk_en_o}, 0);
    rst_ni = 1;
    tick(); tick();
    check(!sys_clk_en_o, "R1 no clock before fast ready", sys_clk_en_o, 0);
    wait_run();
    check(sys_clk_en_o && fast_rdy_i, "R1 clock after fast ready", sys_clk_en_o, 1);
  endtask

  task automatic t_divider();
    int n;
    for (int d = 0; d < 4; d++) begin
      write_cfg(2'd0, 2'(d));
      wait_run();
      count_pulses(32, n);
      check(n == (32 >> d), $sformatf("R3 divide code %0d", d), n, 32 >> d);
    end
  endtask

  task automatic t_switch();
    int busy_cyc = 0, n = 0;
    write_cfg(2'd3, 2'd0);       // code 3 aliases crystal
    wait_run();
    check(cur_src_o == 2'd3 && !fast_en_o, "R2 code 3 runs on crystal", fast_en_o, 0);
    repeat (10) tick();
    check(!fast_rdy_i, "R4 fast oscillator off", fast_rdy_i, 0);
    write_cfg(2'd0, 2'd0);
    for (int i = 0; i < 100 && switch_busy_o; i++) begin
      busy_cyc++;
      if (sys_clk_en_o) n++;
      if (busy_cyc == 3)
        check(cur_src_o == 2'd3, "R4 source held while busy", cur_src_o, 3);
      tick();
    end
    check(busy_cyc >= FAST_STAB - 1, "R4 busy lasts through stabilisation", busy_cyc, FAST_STAB);
    check(n > 0, "R4 clock keeps running during switch", n, 1);
    check(cur_src_o == 2'd0 && fast_rdy_i, "R2 switched back to fast", cur_src_o, 0);
  endtask

  task automatic t_no_deep();
    int n;
    bit slp = 0;
    sleep_req_i = 1; deep_i = 0;
    tick();
    sleep_req_i = 0;
    n = 0;
    for (int i = 0; i < 12; i++) begin
      tick();
      if (sleeping_o) slp = 1;
      if (sys_clk_en_o) n++;
    end
    check(!slp && n == 12, "R5 request without deep ignored", n, 12);
  endtask

  task automatic t_abort();
    int n = 0;
    bit slp = 0;
    sleep_req_i = 1; deep_i = 1;
    tick();
    sleep_req_i = 0; deep_i = 0; wake_irq_i = 1;
    tick();
    wake_irq_i = 0;
    for (int i = 0; i < 16; i++) begin
      if (sleeping_o) slp = 1;
      if (sys_clk_en_o) n++;
      tick();
    end
    check(!slp, "R10 entry aborted", slp, 0);
    check(n == 16, "R10 clock uninterrupted", n, 16);
  endtask

  task automatic t_sleep_stop_xtal();
    int n = 0, bad = 0, first = -1;
    write_cfg(2'd0, 2'd1);
    wait_run();
    xtal_stop_i = 1;
    go_sleep();
    check(sleeping_o, "R5 deep request enters sleep", sleeping_o, 1);
    for (int i = 0; i < 6; i++) begin
      if (sys_clk_en_o || rtc_clk_en_o || xtal_en_o || fast_en_o) n++;
      tick();
    end
    check(n == 0, "R6 clocks and oscillators off in sleep", n, 0);
    pulse_wake();
    for (int i = 0; i < 60; i++) begin
      if (sys_clk_en_o && !fast_rdy_i) bad++;
      if (sys_clk_en_o && first < 0) first = i;
      tick();
    end
    check(bad == 0 && first >= FAST_STAB - 2, "R9 release waits for ready", first, FAST_STAB);
    check(cur_src_o == 2'd0 && cur_div_o == 2'd1, "R7 pre-sleep settings restored",
          {cur_src_o, cur_div_o}, 1);
    xtal_stop_i = 0;
  endtask

  task automatic t_wake_mode();
    int n;
    bit rtc_drop = 0;
    repeat (XTAL_STAB + 2) tick();
    wake_mode_i = 1; wake_src_i = 2'd1; wake_div_i = 2'd2;
    go_sleep();
    for (int i = 0; i < 6; i++) begin
      if (!rtc_clk_en_o) rtc_drop = 1;
      tick();
    end
    check(sleeping_o && !rtc_drop, "R6 rtc kept with crystal running", rtc_drop, 0);
    pulse_wake();
    wait_run();
    check(cur_src_o == 2'd1 && cur_div_o == 2'd2, "R8 wake fields adopted",
          {cur_src_o, cur_div_o}, 6);
    count_pulses(32, n);
    check(n == 8, "R8 wake divider in effect", n, 8);
    wake_mode_i = 0; wake_src_i = 2'd0; wake_div_i = 2'd0;
    go_sleep();
    pulse_wake();
    wait_run();
    check(cur_src_o == 2'd1 && cur_div_o == 2'd2, "R8 wake settings retained",
          {cur_src_o, cur_div_o}, 6);
  endtask

  initial begin
    t_reset();
    t_divider();
    t_switch();
    t_no_deep();
    t_abort();
    t_sleep_stop_xtal();
    t_wake_mode();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule